// File: doc/BRIEF.md
# External Bus Wait-State Generator

This block stretches external program, data and I/O bus cycles by a number of wait states that software programs. A 16-bit configuration register holds five 3-bit wait counts, one for each external address range: two ranges in program space, two in data space and one for the whole of I/O space. A separate one-bit multiplier register doubles the selected count. An access can therefore be stretched by up to 14 machine cycles.

When an access begins, the block decodes its space and address and selects one field. It multiplies the field value and holds the not-ready signal until that many cycles have passed. After that it waits for the external ready input before the cycle completes, so devices that need longer delays can hold the bus themselves. When all five fields are zero, the block drops the clock enable of its wait counter to save power.

Top module: `wsg_top`

## Requirements
- R1: The wait configuration register sits at offset 0x28, resets to 0x7FFF (every field 7, bit 15 clear) and reads back all 16 bits. The multiplier register sits at offset 0x29 in bit 0, resets to 0, and reads back with bits 15:1 as zero. A write lands on the clock edge of its write cycle.
- R2: Space codes are 0 for program, 1 for data, and 2 or 3 for I/O. A program access uses bits 2:0 when its split bit is 0 and bits 5:3 when it is 1. A data access uses bits 8:6 when address bit 15 is 0 and bits 11:9 when it is 1. Every I/O access uses bits 14:12.
- R3: With bit 15 of the configuration register clear, the program split bit is address bit 15. With bit 15 set, it is address bit 23.
- R4: Let N be the selected count, with N > 0 and ready high. An access issued in cycle 0 asserts accDone in cycle N and in no earlier cycle. notReady is high in cycles 0 to N-1.
- R5: When the multiplier bit is 1, the count becomes twice the field value, so a field of 7 gives 14 wait states.
- R6: Once the programmed count has expired, the access completes in the first cycle in which extReady is high. notReady stays high until then.
- R7: An access with a count of zero and extReady high completes in the cycle it is issued.
- R8: cntClkEn is high exactly when at least one of the five wait-count fields is nonzero.
- R9: A register write made while an access is in progress does not change that access's count. The next access uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 8 | Register offset for reads and writes |
| cfgWrData | input | 16 | Register write data |
| cfgRdData | output | 16 | Register read data (combinational) |
| accStart | input | 1 | Pulse in the cycle an external access is issued |
| accSpace | input | 2 | Space of the access: 0 program, 1 data, 2/3 I/O |
| accAddr | input | 24 | Address of the access |
| extReady | input | 1 | External hardware ready |
| notReady | output | 1 | High while the current access must be stretched |
| accDone | output | 1 | High in the cycle the access completes |
| cntClkEn | output | 1 | Clock enable of the wait counter |

## Verification
accDone and notReady are combinational in the current cycle and counter state. Read data and cntClkEn follow the registers in the cycle after the write edge. An access issued in cycle 0 is expected to finish in the later of cycle N and the first cycle with ready high. Each scenario task drives its inputs just after a falling edge and samples 1 ns later, still within the same clock period. It counts the falling edges until accDone appears and compares that count with the value worked out from the field, the multiplier and the ready pattern. The mid-access write test changes the register at cycle 1 of a running access and checks that this access still finishes at its latched count.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

  typedef enum logic [1:0] {
    SP_PROG = 2'd0,
    SP_DATA = 2'd1,
    SP_IO   = 2'd2,
    SP_IO2  = 2'd3
  } accSpace_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCnt;
    logic decCnt;
  } ctrlStrb_t;

endpackage

// File: rtl/wsg_datapath.sv
module wsg_datapath
  import wsg_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int CFG_AW    = 8,
  parameter int FIELD_W   = 3,
  parameter int NUM_FIELDS = 5,
  parameter int LO_SPLIT  = 15,
  parameter logic [CFG_AW-1:0] WSR_OFS = 8'h28,
  parameter logic [CFG_AW-1:0] MUL_OFS = 8'h29,
  localparam int REG_W = FIELD_W * NUM_FIELDS + 1,
  localparam int CNT_W = FIELD_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [REG_W-1:0]  cfgWrData,
  output logic [REG_W-1:0]  cfgRdData,
  input  logic [1:0]        accSpace,
  input  logic [ADDR_W-1:0] accAddr,
  input  ctrlStrb_t         strb,
  output logic [CNT_W-1:0]  waitCount,
  output logic [CNT_W-1:0]  cntVal,
  output logic              cntZero,
  output logic              cntClkEn
);

  localparam logic [REG_W-1:0] WSR_RST = {1'b0, {(REG_W-1){1'b1}}};
  localparam int SPLIT_BIT = REG_W - 1;

  logic [REG_W-1:0]   waitReg;
  logic               multX2;
  logic [FIELD_W-1:0] fieldVal [NUM_FIELDS];
  logic [FIELD_W-1:0] selField;
  logic               progHigh;
  logic               cntEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitReg <= WSR_RST;
      multX2  <= 1'b0;
    end else if (cfgWrEn) begin
      if (cfgAddr == WSR_OFS) waitReg <= cfgWrData;
      if (cfgAddr == MUL_OFS) multX2  <= cfgWrData[0];
    end
  end

  always_comb begin
    cfgRdData = '0;
    if (cfgAddr == WSR_OFS)      cfgRdData = waitReg;
    else if (cfgAddr == MUL_OFS) cfgRdData = {{(REG_W-1){1'b0}}, multX2};
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    assign fieldVal[g] = waitReg[g*FIELD_W +: FIELD_W];
  end

  assign progHigh = waitReg[SPLIT_BIT] ? accAddr[ADDR_W-1] : accAddr[LO_SPLIT];

  always_comb begin
    unique case (accSpace)
      SP_PROG: selField = progHigh ? fieldVal[1] : fieldVal[0];
      SP_DATA: selField = accAddr[LO_SPLIT] ? fieldVal[3] : fieldVal[2];
      default: selField = fieldVal[4];
    endcase
  end

  assign waitCount = multX2 ? {selField, 1'b0} : {1'b0, selField};
  assign cntClkEn  = |waitReg[REG_W-2:0];

  // counter runs while any field is nonzero or an access is draining
  assign cntEn = cntClkEn | strb.decCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal <= '0;
    end else if (cntEn) begin
      if (strb.loadCnt)     cntVal <= waitCount - CNT_W'(1);
      else if (strb.decCnt) cntVal <= cntVal - CNT_W'(1);
    end
  end

  assign cntZero = (cntVal == '0);

endmodule

// File: rtl/wsg_ctrl.sv
module wsg_ctrl
  import wsg_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accStart,
  input  logic             extReady,
  input  logic [CNT_W-1:0] waitCount,
  input  logic             cntZero,
  output ctrlStrb_t        strb,
  output logic             notReady,
  output logic             accDone,
  output logic             busy
);

  ctrlState_e state, nxtState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxtState;
  end

  always_comb begin
    nxtState = state;
    strb     = '0;
    notReady = 1'b0;
    accDone  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (accStart) begin
          if (waitCount == '0) begin
            accDone  = extReady;
            notReady = !extReady;
            if (!extReady) nxtState = ST_BUSY;
          end else begin
            strb.loadCnt = 1'b1;
            notReady     = 1'b1;
            nxtState     = ST_BUSY;
          end
        end
      end
      ST_BUSY: begin
        if (!cntZero) begin
          strb.decCnt = 1'b1;
          notReady    = 1'b1;
        end else begin
          accDone  = extReady;
          notReady = !extReady;
          if (extReady) nxtState = ST_IDLE;
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  assign busy = (state == ST_BUSY);

endmodule

// File: rtl/wsg_top.sv
module wsg_top
  import wsg_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int CFG_AW  = 8,
  parameter int FIELD_W = 3,
  parameter int NUM_FIELDS = 5,
  localparam int REG_W = FIELD_W * NUM_FIELDS + 1,
  localparam int CNT_W = FIELD_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [REG_W-1:0]  cfgWrData,
  output logic [REG_W-1:0]  cfgRdData,
  input  logic              accStart,
  input  logic [1:0]        accSpace,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              extReady,
  output logic              notReady,
  output logic              accDone,
  output logic              cntClkEn
);

  ctrlStrb_t        strb;
  logic [CNT_W-1:0] waitCount;
  logic [CNT_W-1:0] cntVal;
  logic             cntZero;
  logic             busy;

  wsg_datapath #(
    .ADDR_W(ADDR_W), .CFG_AW(CFG_AW), .FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .accSpace(accSpace),
    .accAddr(accAddr), .strb(strb), .waitCount(waitCount), .cntVal(cntVal),
    .cntZero(cntZero), .cntClkEn(cntClkEn)
  );

  wsg_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .accStart(accStart), .extReady(extReady),
    .waitCount(waitCount), .cntZero(cntZero), .strb(strb),
    .notReady(notReady), .accDone(accDone), .busy(busy)
  );

endmodule

// File: rtl/wsg_checker.sv
module wsg_checker #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             accStart,
  input logic             extReady,
  input logic             notReady,
  input logic             accDone,
  input logic             cntClkEn,
  input logic             busy,
  input logic             cntZero,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] waitCount
);

  // R6: completion requires the external ready line
  a_r6_done_needs_ready: assert property (@(posedge clk) disable iff (!rstN)
    accDone |-> extReady);

  // R7: zero count with ready finishes in the issue cycle
  a_r7_zero_wait: assert property (@(posedge clk) disable iff (!rstN)
    (accStart && !busy && waitCount == '0 && extReady) |-> accDone);

  // R4: while the count runs the bus is held
  a_r4_hold_while_counting: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cntZero) |-> (notReady && !accDone));

  // R4: the counter steps down by one per stretched cycle
  a_r4_count_down: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cntZero) |=> (cntVal == $past(cntVal) - CNT_W'(1)));

  // R6: an unfinished access stays pending
  a_r6_stay_pending: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !accDone) |=> busy);

  // R8: with the counter clock off and no access pending, the counter is frozen
  a_r8_gated_counter: assert property (@(posedge clk) disable iff (!rstN)
    (!cntClkEn && !busy) |=> $stable(cntVal));

endmodule

bind wsg_top wsg_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .accStart(accStart), .extReady(extReady),
  .notReady(notReady), .accDone(accDone), .cntClkEn(cntClkEn), .busy(busy),
  .cntZero(cntZero), .cntVal(cntVal), .waitCount(waitCount)
);

// File: tb/wsg_top_tb_top.sv
`timescale 1ns/1ps
module wsg_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrEn;
  logic [7:0]  cfgAddr;
  logic [15:0] cfgWrData;
  logic [15:0] cfgRdData;
  logic        accStart;
  logic [1:0]  accSpace;
  logic [23:0] accAddr;
  logic        extReady;
  logic        notReady;
  logic        accDone;
  logic        cntClkEn;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  wsg_top dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .accStart(accStart),
    .accSpace(accSpace), .accAddr(accAddr), .extReady(extReady),
    .notReady(notReady), .accDone(accDone), .cntClkEn(cntClkEn)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] ofs, input logic [15:0] val);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = ofs; cfgWrData = val;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic readCheck(input logic [7:0] ofs, input logic [15:0] exp, input string tag);
    @(negedge clk);
    cfgAddr = ofs;
    #1;
    check(cfgRdData == exp, tag, cfgRdData, exp);
  endtask

  // issue one access; ready is low for cycles k < rdyLow
  task automatic runAcc(input logic [1:0] sp, input logic [23:0] ad,
                        input int rdyLow, input int expN, input string tag);
    int k = 0;
    bit holdBad = 1'b0;
    @(negedge clk);
    accSpace = sp; accAddr = ad; accStart = 1'b1; extReady = (rdyLow == 0);
    #1;
    while (!accDone && k < 40) begin
      if (!notReady) holdBad = 1'b1;
      @(negedge clk);
      accStart = 1'b0;
      k++;
      extReady = (k >= rdyLow);
      #1;
    end
    check(k == expN, tag, k, expN);
    check(!holdBad, {tag, " notReady held"}, holdBad, 0);
    @(negedge clk);
    accStart = 1'b0; extReady = 1'b1;
  endtask

  task automatic testReset();
    readCheck(8'h28, 16'h7FFF, "R1 reset wait register");
    readCheck(8'h29, 16'h0000, "R1 reset multiplier");
    check(cntClkEn == 1'b1, "R8 clock enable after reset", cntClkEn, 1);
    runAcc(2'd0, 24'h000000, 0, 7, "R4 default seven waits");
  endtask

  task automatic testFields();
    writeReg(8'h28, 16'h58D1);
    readCheck(8'h28, 16'h58D1, "R1 readback fields");
    runAcc(2'd0, 24'h001000, 0, 1, "R2 program low field");
    runAcc(2'd0, 24'h008000, 0, 2, "R2 program high field");
    runAcc(2'd1, 24'h000100, 0, 3, "R2 data low field");
    runAcc(2'd1, 24'h00F000, 0, 4, "R2 data high field");
    runAcc(2'd2, 24'h000050, 0, 5, "R2 io field");
    runAcc(2'd3, 24'h00FFFF, 0, 5, "R2 io field code 3");
  endtask

  task automatic testSplit();
    writeReg(8'h28, 16'hD8D1);
    readCheck(8'h28, 16'hD8D1, "R1 readback bit15");
    runAcc(2'd0, 24'h008000, 0, 1, "R3 split on bit23 low");
    runAcc(2'd0, 24'h800000, 0, 2, "R3 split on bit23 high");
    runAcc(2'd1, 24'h808000, 0, 4, "R3 data split unchanged");
  endtask

  task automatic testMult();
    writeReg(8'h29, 16'h0001);
    readCheck(8'h29, 16'h0001, "R1 multiplier readback");
    runAcc(2'd2, 24'h000000, 0, 10, "R5 io doubled");
    runAcc(2'd0, 24'h800000, 0, 4, "R5 program doubled");
    writeReg(8'h28, 16'h7FFF);
    runAcc(2'd1, 24'h000000, 0, 14, "R5 maximum fourteen");
    writeReg(8'h29, 16'h0000);
  endtask

  task automatic testReady();
    writeReg(8'h28, 16'h0002);
    runAcc(2'd0, 24'h000000, 5, 5, "R6 ready extends past count");
    runAcc(2'd0, 24'h000000, 1, 2, "R6 early ready ignored until count");
  endtask

  task automatic testZero();
    writeReg(8'h28, 16'h0000);
    @(negedge clk); #1;
    check(cntClkEn == 1'b0, "R8 clock enable off all zero", cntClkEn, 0);
    runAcc(2'd1, 24'h001234, 0, 0, "R7 zero wait same cycle");
    runAcc(2'd2, 24'h000000, 3, 3, "R6 zero wait ready extension");
    writeReg(8'h28, 16'h1000);
    @(negedge clk); #1;
    check(cntClkEn == 1'b1, "R8 clock enable io only", cntClkEn, 1);
  endtask

  task automatic testMidWrite();
    int k = 0;
    writeReg(8'h28, 16'h0100);
    @(negedge clk);
    accSpace = 2'd1; accAddr = 24'h000010; accStart = 1'b1; extReady = 1'b1;
    #1;
    while (!accDone && k < 40) begin
      @(negedge clk);
      accStart = 1'b0;
      k++;
      if (k == 1) begin cfgWrEn = 1'b1; cfgAddr = 8'h28; cfgWrData = 16'h0040; end
      else cfgWrEn = 1'b0;
      #1;
    end
    check(k == 4, "R9 running access keeps latched count", k, 4);
    @(negedge clk);
    cfgWrEn = 1'b0;
    runAcc(2'd1, 24'h000010, 0, 1, "R9 next access uses new count");
  endtask

  initial begin
    rstN = 1'b0; cfgWrEn = 1'b0; cfgAddr = '0; cfgWrData = '0;
    accStart = 1'b0; accSpace = '0; accAddr = '0; extReady = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testFields();
    testSplit();
    testMult();
    testReady();
    testZero();
    testMidWrite();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule